// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the memory stage of a 32-bit load/store pipeline and a word-wide data memory port. For every access it forms the effective address from a base register value and a signed 16-bit displacement and checks that address against the access size. For a store it drives write data that carries the source value on every lane it could land on, and byte-enables that select the lanes actually written. For a load it raises a read request and keeps the lane and size of the access. When the memory returns the word, the unit picks out the addressed byte or halfword, widens it with either sign or zero extension, and registers the result.

Lanes are numbered big-endian: address offset 0 within a word is bits 31..24. A misaligned access is not performed. The unit raises a fault flag in the same cycle, holds every byte-enable low and issues no read. Only one load is outstanding at a time, and the memory answers no earlier than the cycle after the request.

Top module: `ls_lane_unit`

## Requirements
- R1: `memAddr` equals `baseAddr` plus `offset` sign-extended to 32 bits (modulo 2^32), combinationally in the request cycle.
- R2: A word access (`reqSize` = 2'b10 or 2'b11) whose effective address bits [1:0] are not 00 is misaligned.
- R3: A halfword access (`reqSize` = 2'b01) with effective address bit 0 set is misaligned. A byte access (`reqSize` = 2'b00) is never misaligned.
- R4: For a misaligned request `fault` is high in that same cycle, `memByteEn` is 4'b0000 and `memRead` is low. `fault` is never high without `reqValid`.
- R5: For an aligned store, `memByteEn` is 4'b1111 for a word, 4'b1100 at offset 0 or 4'b0011 at offset 2 for a halfword, and 4'b1000 >> offset for a byte, where enable bit 3 covers data bits 31..24. With no aligned store, `memByteEn` is 4'b0000.
- R6: For a store, `memWrData` is the whole `storeData` for a word, the low 16 bits of `storeData` repeated twice for a halfword, and the low 8 bits repeated four times for a byte.
- R7: A byte load returns byte `memRdData[31-8k -: 8]` for offset k. With `reqSigned`=1 its bit 7 fills bits 31..8; with `reqSigned`=0 those bits are zero.
- R8: A halfword load returns `memRdData[31:16]` at offset 0 and `memRdData[15:0]` at offset 2. With `reqSigned`=1 its bit 15 fills the upper 16 bits; with `reqSigned`=0 those bits are zero.
- R9: A word load returns `memRdData` unchanged. An aligned load request drives `memRead` high in the request cycle.
- R10: `loadValid` is high exactly in the cycle after a cycle with `memRdValid` high, and `loadData` then holds the extended result of that returned word.
- R11: After reset, `loadValid` is low and `loadData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | An access is presented this cycle |
| reqStore | input | 1 | 1 for a store, 0 for a load |
| reqSize | input | 2 | 00 byte, 01 halfword, 1x word |
| reqSigned | input | 1 | Sign-extend a byte or halfword load |
| baseAddr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| storeData | input | 32 | Source register value for stores |
| memAddr | output | 32 | Effective address |
| memByteEn | output | 4 | Write enables, bit 3 = bits 31..24 |
| memWrData | output | 32 | Lane-replicated write data |
| memRead | output | 1 | Aligned load request |
| fault | output | 1 | Misaligned access flag |
| memRdValid | input | 1 | Memory returns read data this cycle |
| memRdData | input | 32 | Returned memory word |
| loadData | output | 32 | Registered, extended load result |
| loadValid | output | 1 | loadData is valid this cycle |

## Verification
The only state is the captured lane, size and signedness of the outstanding load, plus the result register. A corrupted capture shows up at the first returned word: the result register then takes the wrong byte, the wrong half, or the wrong fill in bits 31..8. That error appears on `loadData` one cycle after `memRdValid`. Every request-side output is combinational, so a wrong lane decode or alignment check is visible on `memByteEn`, `memRead` or `fault` in the request cycle itself. For that reason the sweep covers every address offset with every size, direction and extension mode, and it checks the result of each load against a value computed from the returned word.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  typedef struct packed {
    logic              capture;
    logic [LANE_W-1:0] lane;
    logic [1:0]        size;
    logic              signExt;
  } laneCtrlT;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  offset,
  input  logic              memRdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic              memRead,
  output logic              fault,
  output laneCtrlT          ctrl
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [LANE_W-1:0] lane;
  logic              isWord, isHalf, misAligned, goAccess;
  logic [LANE_W-1:0] pendLane;
  logic [1:0]        pendSize;
  logic              pendSigned;

  assign memAddr    = baseAddr + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign lane       = memAddr[LANE_W-1:0];
  assign isWord     = reqSize[1];
  assign isHalf     = (reqSize == SZ_HALF);
  assign misAligned = isWord ? (|lane) : (isHalf ? lane[0] : 1'b0);
  assign fault      = reqValid & misAligned;
  assign goAccess   = reqValid & ~misAligned;
  assign memRead    = goAccess & ~reqStore;

  always_comb begin
    memByteEn = '0;
    if (goAccess && reqStore) begin
      if (isWord)      memByteEn = '1;
      else if (isHalf) memByteEn = lane[1] ? 4'b0011 : 4'b1100;
      else             memByteEn = 4'b1000 >> lane;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendLane   <= '0;
      pendSize   <= '0;
      pendSigned <= 1'b0;
    end else if (memRead) begin
      pendLane   <= lane;
      pendSize   <= reqSize;
      pendSigned <= reqSigned;
    end
  end

  assign ctrl = '{capture: memRdValid, lane: pendLane, size: pendSize, signExt: pendSigned};

  // R4
  a_r4_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (memByteEn == 4'b0000 && !memRead));
  a_r4_fault_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> reqValid);
  // R2
  a_r2_word_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqSize[1] && memAddr[1:0] != 2'b00) |-> fault);
  // R3
  a_r3_byte_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqSize == SZ_BYTE) |-> !fault);
  // R5
  a_r5_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqStore && reqSize == SZ_BYTE) |-> $onehot(memByteEn));
  a_r5_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqStore && !fault && reqSize == SZ_HALF) |->
      (memByteEn == 4'b1100 || memByteEn == 4'b0011));
  a_r5_no_store_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && reqStore) |-> (memByteEn == 4'b0000));
endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdData,
  input  laneCtrlT          ctrl,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);
  localparam int HALF_W = DATA_W / 2;

  logic [7:0]        pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic [DATA_W-1:0] extended;
  logic [1:0]        resSize;
  logic              resSigned;

  always_comb begin
    if (reqSize[1])             memWrData = storeData;
    else if (reqSize == SZ_HALF) memWrData = {2{storeData[HALF_W-1:0]}};
    else                        memWrData = {LANES{storeData[7:0]}};
  end

  always_comb begin
    pickByte = memRdData[8*(LANES-1-int'(ctrl.lane)) +: 8];
    pickHalf = ctrl.lane[1] ? memRdData[HALF_W-1:0] : memRdData[DATA_W-1:HALF_W];
    if (ctrl.size[1])
      extended = memRdData;
    else if (ctrl.size == SZ_HALF)
      extended = {{HALF_W{ctrl.signExt & pickHalf[HALF_W-1]}}, pickHalf};
    else
      extended = {{(DATA_W-8){ctrl.signExt & pickByte[7]}}, pickByte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadData  <= '0;
      loadValid <= 1'b0;
      resSize   <= '0;
      resSigned <= 1'b0;
    end else begin
      loadValid <= ctrl.capture;
      if (ctrl.capture) begin
        loadData  <= extended;
        resSize   <= ctrl.size;
        resSigned <= ctrl.signExt;
      end
    end
  end

  // R10
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.capture |=> loadValid);
  a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.capture |=> !loadValid);
  // R7
  a_r7_byte_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (loadValid && resSize == SZ_BYTE && !resSigned) |-> (loadData[DATA_W-1:8] == '0));
  a_r7_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (loadValid && resSize == SZ_BYTE && resSigned) |->
      (loadData[DATA_W-1:8] == {(DATA_W-8){loadData[7]}}));
  // R8
  a_r8_half_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (loadValid && resSize == SZ_HALF && !resSigned) |-> (loadData[DATA_W-1:HALF_W] == '0));
  // R10: result register holds between returns
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.capture |=> $stable(loadData));
endmodule

// File: rtl/ls_lane_unit.sv
module ls_lane_unit
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] storeData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRead,
  output logic              fault,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);
  laneCtrlT ctrl;

  lane_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .reqSigned(reqSigned), .baseAddr(baseAddr),
    .offset(offset), .memRdValid(memRdValid), .memAddr(memAddr),
    .memByteEn(memByteEn), .memRead(memRead), .fault(fault), .ctrl(ctrl)
  );

  lane_datapath u_data (
    .clk(clk), .rst_n(rst_n), .reqSize(reqSize), .storeData(storeData),
    .memRdData(memRdData), .ctrl(ctrl), .memWrData(memWrData),
    .loadData(loadData), .loadValid(loadValid)
  );
endmodule

// File: tb/ls_lane_unit_test.sv
module ls_lane_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqSigned = 1'b0;
  logic [1:0]  reqSize = 2'b00;
  logic [31:0] baseAddr = '0, storeData = '0, memRdData = '0;
  logic [15:0] offset = '0;
  logic        memRdValid = 1'b0;
  logic [31:0] memAddr, memWrData, loadData;
  logic [3:0]  memByteEn;
  logic        memRead, fault, loadValid;

  int checks = 0;
  int errors = 0;

  ls_lane_unit uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .reqSigned(reqSigned), .baseAddr(baseAddr),
    .offset(offset), .storeData(storeData), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWrData(memWrData), .memRead(memRead),
    .fault(fault), .memRdValid(memRdValid), .memRdData(memRdData),
    .loadData(loadData), .loadValid(loadValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expEn(input logic [1:0] sz, input logic [1:0] lo);
    if (sz[1]) return 4'b1111;
    if (sz == 2'b01) return (lo == 2'd0) ? 4'b1100 : 4'b0011;
    return 4'b1000 >> lo;
  endfunction

  function automatic logic [31:0] expLoad(input logic [1:0] sz, input logic [1:0] lo,
                                          input logic sg, input logic [31:0] w);
    logic [31:0] v;
    if (sz[1]) return w;
    if (sz == 2'b01) begin
      v = (lo == 2'd0) ? (w >> 16) : (w & 32'h0000_FFFF);
      v = v & 32'h0000_FFFF;
      if (sg && v >= 32'h8000) v = v | 32'hFFFF_0000;
      return v;
    end
    v = (w >> (8 * (3 - lo))) & 32'hFF;
    if (sg && v >= 32'h80) v = v | 32'hFFFF_FF00;
    return v;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [15:0] offs [5];
    logic [31:0] ea, word, expW;
    logic [1:0]  lo;
    logic        mis;
    int          iter;
    offs[0] = 16'h0000; offs[1] = 16'h0004; offs[2] = 16'hFFFC;
    offs[3] = 16'h7FFD; offs[4] = 16'h8002;
    iter = 0;

    @(negedge clk);
    #1;
    check("R11 reset loadValid", {31'b0, loadValid}, 32'd0);
    check("R11 reset loadData", loadData, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle byteEn", {28'b0, memByteEn}, 32'd0);
    check("R4 idle fault", {31'b0, fault}, 32'd0);

    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 5; o++)
        for (int sz = 0; sz < 4; sz++)
          for (int st = 0; st < 2; st++)
            for (int sg = 0; sg < 2; sg++) begin
              iter++;
              word = 32'h80F1_7F03 ^ (iter * 32'h9E37_79B9);
              baseAddr  = 32'h1000_0000 + 32'(b) + 32'(iter * 16);
              offset    = offs[o];
              reqSize   = 2'(sz);
              reqStore  = st[0];
              reqSigned = sg[0];
              storeData = ~word;
              reqValid  = 1'b1;
              ea = baseAddr + {{16{offs[o][15]}}, offs[o]};
              lo = ea[1:0];
              mis = (sz >= 2) ? (lo != 2'd0) : ((sz == 1) ? lo[0] : 1'b0);
              #1;
              check("R1 address", memAddr, ea);
              check(sz >= 2 ? "R2 word fault" : "R3 half/byte fault", {31'b0, fault}, {31'b0, mis});
              if (mis) begin
                check("R4 fault byteEn", {28'b0, memByteEn}, 32'd0);
                check("R4 fault memRead", {31'b0, memRead}, 32'd0);
              end else if (st == 1) begin
                check("R5 byteEn", {28'b0, memByteEn}, {28'b0, expEn(2'(sz), lo)});
                if (sz >= 2) expW = ~word;
                else if (sz == 1) expW = {2{~word[15:0]}};
                else expW = {4{~word[7:0]}};
                check("R6 store data", memWrData, expW);
              end else begin
                check("R9 memRead", {31'b0, memRead}, 32'd1);
                check("R5 load byteEn", {28'b0, memByteEn}, 32'd0);
              end
              @(negedge clk);
              reqValid = 1'b0;
              if (!mis && st == 0) begin
                memRdValid = 1'b1;
                memRdData  = word;
                @(negedge clk);
                memRdValid = 1'b0;
                memRdData  = 32'hDEAD_BEEF;
                check("R10 loadValid", {31'b0, loadValid}, 32'd1);
                check(sz >= 2 ? "R9 word load" : (sz == 1 ? "R8 half load" : "R7 byte load"),
                      loadData, expLoad(2'(sz), lo, sg[0], word));
                @(negedge clk);
                check("R10 loadValid drop", {31'b0, loadValid}, 32'd0);
                check("R10 loadData hold", loadData, expLoad(2'(sz), lo, sg[0], word));
              end
            end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule